// File: doc/BRIEF.md
# Bus Clock Loss Monitor

This block watches a slow bus clock and raises a reset request when that clock stops or its period grows too long. The time between bus-clock rising edges is measured with a separate reference clock that always runs. Each rising edge is passed through a synchroniser into the reference domain and restarts a gap counter. If the counter reaches a single fixed limit before the next edge arrives, the block flags a clock loss. The limit sits between the longest period that must always pass and the shortest period that must always trip. With the system defaults these two bounds are the period of a 200 kHz bus clock and the period of a 10 kHz bus clock.

Two control bits decide whether the monitor runs. The enable bit can be written at any time. The lock bit can only be set; once set it keeps the monitor running until the next reset. A low-power clock stop therefore causes a reset request whenever the monitor is running. The request stays high until the reset controller pulls `rst_n` low. That same reset also clears both control bits. The bus clock is normally one quarter of the crystal frequency; the block only uses its edges.

Top module: `bus_clock_guard`

## Requirements
- R1: After `rst_n` is released, `reset_req` is 0 and `mon_active` is 0.
- R2: While `mon_active` is 0, `reset_req` never rises, even if the bus clock is stopped for any length of time.
- R3: While running, a bus clock whose rising edges are at most PASS_CYC reference cycles apart never raises `reset_req`. The same holds for any period below the trip limit LIMIT = (PASS_CYC + TRIP_CYC) / 2.
- R4: While running, a bus clock with a period of TRIP_CYC or more raises `reset_req`. `reset_req` rises about LIMIT reference cycles after the last synchronised rising edge; the synchroniser adds three reference cycles of latency.
- R5: A bus clock that stops high trips the monitor, and so does one that stops low. The trip comes LIMIT reference cycles after the last rising edge in both cases.
- R6: A write with `cfg_we`=1 sets the enable bit to `cfg_enable` at any time. Clearing it stops the gap timing and discards any partial count. Setting it again starts a fresh full LIMIT window.
- R7: A write with `cfg_force`=1 sets the lock bit. While the lock bit is set, `mon_active` is 1 and writes that clear the enable bit or `cfg_force` have no effect on it.
- R8: Once `reset_req` is 1, it stays 1 until `rst_n` goes low. Clearing the enable bit does not lower it, and neither do new bus-clock edges.
- R9: `rst_n` low clears the enable bit, the lock bit and `reset_req`, so `mon_active` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all state is clocked by it |
| rst_n | input | 1 | Active-low asynchronous reset from the reset controller |
| bus_clk | input | 1 | Monitored bus clock, sampled as data |
| cfg_we | input | 1 | Control write strobe, one reference cycle |
| cfg_enable | input | 1 | New value of the enable bit on a write |
| cfg_force | input | 1 | 1 on a write sets the lock bit (set-only) |
| mon_active | output | 1 | Monitor running: enable bit OR lock bit |
| reset_req | output | 1 | Sticky clock-loss reset request |

## Verification
The assertions take the bus clock to be much slower than the reference clock, so the synchroniser never misses or merges a rising edge. They also take `rst_n` to be the only path that clears a pending request. The bench keeps to this by running the bus clock with half-periods of hundreds of nanoseconds against a 5 ns reference. It changes `cfg_*` only on falling reference edges. It stops the bus clock right after a known edge, so that the trip window can be measured from the last rising edge.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;
  // Trip limit: midpoint of the must-pass and must-trip periods, which
  // leaves margin on both sides for reference-clock tolerance.
  function automatic int gap_limit(input int pass_cyc, input int trip_cyc);
    return (pass_cyc + trip_cyc) / 2;
  endfunction

  function automatic int cnt_width(input int limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/clkmon_edge_sync.sv
`timescale 1ns/1ps
module clkmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge ref_clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge ref_clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clkmon_ctrl.sv
`timescale 1ns/1ps
module clkmon_ctrl (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_enable,
  input  logic cfg_force,
  output logic lock_on,
  output logic active
);
  logic en_q;
  logic lock_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)      en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_enable;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                  lock_q <= 1'b0;
    else if (cfg_we && cfg_force) lock_q <= 1'b1;

  assign lock_on = lock_q;
  assign active  = en_q | lock_q;
endmodule

// File: rtl/clkmon_gap_timer.sv
`timescale 1ns/1ps
module clkmon_gap_timer #(
  parameter int LIMIT = 10500,
  parameter int CW    = 14
) (
  input  logic          ref_clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          rise,
  output logic [CW-1:0] gap_cnt,
  output logic          expired,
  output logic          req
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          req_q;

  assign expired = active && !req_q && !rise && (cnt_q == LAST);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                                cnt_q <= '0;
    else if (!active || req_q || rise || expired) cnt_q <= '0;
    else                                       cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)       req_q <= 1'b0;
    else if (expired) req_q <= 1'b1;

  assign gap_cnt = cnt_q;
  assign req     = req_q;
endmodule

// File: rtl/bus_clock_guard.sv
`timescale 1ns/1ps
module bus_clock_guard #(
  parameter int PASS_CYC    = 1000,
  parameter int TRIP_CYC    = 20000,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic bus_clk,
  input  logic cfg_we,
  input  logic cfg_enable,
  input  logic cfg_force,
  output logic mon_active,
  output logic reset_req
);
  localparam int LIMIT = clkmon_pkg::gap_limit(PASS_CYC, TRIP_CYC);
  localparam int CW    = clkmon_pkg::cnt_width(LIMIT);

  logic          bus_rise;
  logic          lock_on;
  logic          gap_expired;
  logic [CW-1:0] gap_cnt;

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .async_in(bus_clk),
    .rise    (bus_rise)
  );

  clkmon_ctrl u_ctrl (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_enable(cfg_enable),
    .cfg_force (cfg_force),
    .lock_on   (lock_on),
    .active    (mon_active)
  );

  clkmon_gap_timer #(.LIMIT(LIMIT), .CW(CW)) u_gap (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .active (mon_active),
    .rise   (bus_rise),
    .gap_cnt(gap_cnt),
    .expired(gap_expired),
    .req    (reset_req)
  );
endmodule

// File: rtl/clkmon_checks.sv
`timescale 1ns/1ps
module clkmon_checks #(
  parameter int LIMIT = 10500,
  parameter int CW    = 14
) (
  input logic          ref_clk,
  input logic          rst_n,
  input logic          mon_active,
  input logic          lock_on,
  input logic          gap_expired,
  input logic [CW-1:0] gap_cnt,
  input logic          reset_req
);
  // R4: counter never passes the trip limit
  p_cnt_bound_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gap_cnt < CW'(LIMIT));

  // R4: a request only appears after the gap timer expired while running
  p_req_cause_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(gap_expired) && $past(mon_active)));

  // R2: idle monitor raises nothing
  p_idle_no_req_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!mon_active && !reset_req) |=> !reset_req);

  // R8: request is sticky until reset
  p_req_sticky_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  // R7: lock bit is set-only
  p_lock_sticky_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lock_on |=> lock_on);

  // R7: lock keeps the monitor running
  p_lock_active_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lock_on |-> mon_active);
endmodule

bind bus_clock_guard clkmon_checks #(.LIMIT(LIMIT), .CW(CW)) u_checks (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .mon_active (mon_active),
  .lock_on    (lock_on),
  .gap_expired(gap_expired),
  .gap_cnt    (gap_cnt),
  .reset_req  (reset_req)
);

// File: tb/bus_clock_guard_test.sv
`timescale 1ns/1ps
module bus_clock_guard_test;
  localparam int PASS  = 100;
  localparam int TRIP  = 2000;
  localparam int LIMIT = (PASS + TRIP) / 2;   // 1050 reference cycles

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_force = 1'b0;
  logic mon_active, reset_req;

  int errors = 0;
  int checks = 0;
  bit bus_run = 1'b0;
  int bus_half = 250;  // ns

  bus_clock_guard #(.PASS_CYC(PASS), .TRIP_CYC(TRIP)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .bus_clk(bus_clk),
    .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_force(cfg_force),
    .mon_active(mon_active), .reset_req(reset_req)
  );

  always #2.5 ref_clk = ~ref_clk;

  initial begin
    #1.3;
    forever begin
      if (bus_run) begin
        #(bus_half);
        bus_clk = ~bus_clk;
      end else @(posedge ref_clk);
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic do_reset();
    bus_run = 1'b0;
    @(negedge ref_clk) rst_n = 1'b0;
    wait_cyc(4);
    @(negedge ref_clk) rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic write_cfg(input logic en, input logic frc);
    @(negedge ref_clk);
    cfg_we = 1'b1; cfg_enable = en; cfg_force = frc;
    @(negedge ref_clk);
    cfg_we = 1'b0; cfg_enable = 1'b0; cfg_force = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 reset_req after reset", reset_req, 1'b0);
    check("R1 mon_active after reset", mon_active, 1'b0);
  endtask

  task automatic t_disabled();
    do_reset();
    wait_cyc(3 * LIMIT);
    check("R2 no request while disabled", reset_req, 1'b0);
  endtask

  task automatic t_fast_clock();
    do_reset();
    bus_half = 250; bus_run = 1'b1;          // period 100 cycles
    write_cfg(1'b1, 1'b0);
    wait_cyc(4 * LIMIT);
    check("R3 pass-rate clock no trip", reset_req, 1'b0);
    bus_half = 2000;                         // period 800 cycles < LIMIT
    wait_cyc(4 * LIMIT);
    check("R3 in-band clock below limit no trip", reset_req, 1'b0);
  endtask

  task automatic t_slow_clock();
    do_reset();
    bus_half = 5000; bus_run = 1'b1;         // period 2000 cycles
    write_cfg(1'b1, 1'b0);
    wait_cyc(LIMIT - 10);
    check("R4 slow clock before limit", reset_req, 1'b0);
    wait_cyc(30);
    check("R4 slow clock trips", reset_req, 1'b1);
  endtask

  task automatic t_stop_low();
    do_reset();
    bus_half = 250; bus_run = 1'b1;
    write_cfg(1'b1, 1'b0);
    wait_cyc(500);
    @(posedge bus_clk);
    bus_run = 1'b0;                          // one more fall, then stays low
    wait_cyc(LIMIT - 6);
    check("R5 stop low before limit", reset_req, 1'b0);
    wait_cyc(16);
    check("R5 stop low trips", reset_req, 1'b1);
    check("R5 bus held low", bus_clk, 1'b0);
  endtask

  task automatic t_stop_high();
    do_reset();
    bus_half = 250; bus_run = 1'b1;
    write_cfg(1'b1, 1'b0);
    wait_cyc(500);
    @(negedge bus_clk);
    bus_run = 1'b0;                          // one more rise, then stays high
    @(posedge bus_clk);
    wait_cyc(LIMIT - 6);
    check("R5 stop high before limit", reset_req, 1'b0);
    wait_cyc(16);
    check("R5 stop high trips", reset_req, 1'b1);
    check("R5 bus held high", bus_clk, 1'b1);
  endtask

  task automatic t_enable_toggle();
    do_reset();
    write_cfg(1'b1, 1'b0);
    check("R6 enable takes effect", mon_active, 1'b1);
    wait_cyc(LIMIT / 2);
    write_cfg(1'b0, 1'b0);
    check("R6 enable cleared", mon_active, 1'b0);
    wait_cyc(2 * LIMIT);
    check("R6 disable cancels pending trip", reset_req, 1'b0);
    write_cfg(1'b1, 1'b0);
    wait_cyc(LIMIT - 8);
    check("R6 fresh window after re-enable", reset_req, 1'b0);
    wait_cyc(16);
    check("R6 trip after full window", reset_req, 1'b1);
  endtask

  task automatic t_force();
    do_reset();
    write_cfg(1'b0, 1'b1);
    check("R7 lock starts monitor", mon_active, 1'b1);
    write_cfg(1'b0, 1'b0);
    wait_cyc(3);
    check("R7 disable ignored under lock", mon_active, 1'b1);
    wait_cyc(LIMIT + 16);
    check("R7 locked monitor trips on stop", reset_req, 1'b1);
    do_reset();
    check("R9 lock cleared by reset", mon_active, 1'b0);
    check("R9 request cleared by reset", reset_req, 1'b0);
  endtask

  task automatic t_sticky();
    do_reset();
    write_cfg(1'b1, 1'b0);
    wait_cyc(LIMIT + 16);
    check("R8 trip before sticky test", reset_req, 1'b1);
    write_cfg(1'b0, 1'b0);
    bus_half = 250; bus_run = 1'b1;
    wait_cyc(500);
    check("R8 request held after disable and edges", reset_req, 1'b1);
    check("R8 monitor idle", mon_active, 1'b0);
    do_reset();
    check("R8 request released by reset", reset_req, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_disabled();
        t_fast_clock();
        t_slow_clock();
        t_stop_low();
        t_stop_high();
        t_enable_toggle();
        t_force();
        t_sticky();
      end
      begin
        repeat (150000) @(posedge ref_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule